// File: doc/BRIEF.md
# Dual-Mode DRAM Access Sequencer

This block runs one processor-side access to a video DRAM array. A chip select qualified by an address strobe raises a start request. The block holds that request while the memory is busy or still in precharge. It then asserts the row strobe, switches the address multiplexer from the row address to the column address, and asserts the column strobes. The access ends when the access-hold input falls. Refresh generation, arbitration between ports and address counters sit outside the block. A single `busy` input tells it when another agent owns the array.

A mode bit picks one of two start styles. In the registered style, an active-high strobe pulse is captured and the row strobe rises on the clock edge that samples it. In the immediate style, an active-low strobe goes low while the chip select is high, and the row strobe follows that strobe through logic in the same cycle. Further configuration bits control four things: whether the column address is held only briefly so the next address can be pipelined; whether column strobes may outlast the row strobe while their lane-keep inputs stay high; whether a write cycle adds one clock before the column strobe; and whether an acknowledge is driven. All interval lengths are parameters given in clock cycles.

Top module: `vram_acc_seq`

## Requirements
- R1: After reset, row strobe, column strobes, mux select, read-output enable and acknowledge are all low, and the first request starts with no precharge wait.
- R2: With `cfg_mode1`=0, a rising `start_stb` sampled with `sel` high on an idle, ready array makes `row_stb_o` rise on that same clock edge.
- R3: With `cfg_mode1`=1, a falling `start_stb` while `sel` is high on an idle, ready array drives `row_stb_o` high within that same cycle, before the next clock edge.
- R4: A request that meets `busy` high, or that arrives before PRECHARGE cycles have passed since the row strobe fell, is held pending. The row strobe then rises on the first edge that samples `busy` low with the precharge count expired. After a fall, the earliest registered rise is PRECHARGE+1 edges later.
- R5: `col_sel_o` rises ROW_HOLD edges after the row strobe edge. The column strobes all rise COL_SETUP edges after that.
- R6: With `cfg_wr_delay`=1 and `wr_cyc` high at the start of the access, the column strobes rise one edge later than in R5.
- R7: With `cfg_pipe`=1, `col_sel_o` falls COL_HOLD edges after the column strobes rise. With `cfg_pipe`=0, it stays high until the access ends.
- R8: At the edge that samples `acc_hold` low during the column phase, `row_stb_o`, `col_sel_o` and `ack_o` fall. The column strobes fall at that edge too unless R9 applies.
- R9: With `cfg_cas_ext`=1, column strobe lane i stays high after the access ends for as long as `col_keep[i]` is sampled high. It falls at the first edge that samples `col_keep[i]` low.
- R10: `rd_oe_o` equals the OR of the column strobes when `cfg_cas_ext`=1 and the access was a read (`wr_cyc` low at start). In every other case it is low.
- R11: With `cfg_ack_en`=1, `ack_o` rises together with the column strobes. With `cfg_ack_en`=0, it never rises.
- R12: With `cfg_pipe`=1, a strobe that arrives during an access is kept as a pending request, provided `acc_hold` was sampled high at an earlier edge of that access (registered style) or is high now (immediate style). A strobe arriving before that point is dropped. With `cfg_pipe`=0, every strobe during an access is dropped.
- R13: In the immediate style, a strobe held low across the end of an access starts nothing new. A fresh high-to-low transition is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode1 | input | 1 | 0: registered start on rising strobe; 1: immediate start on falling strobe |
| cfg_pipe | input | 1 | Column address held only COL_HOLD cycles |
| cfg_cas_ext | input | 1 | Column strobes may outlast the row strobe |
| cfg_wr_delay | input | 1 | Write cycles add one clock before the column strobe |
| cfg_ack_en | input | 1 | Drive the acknowledge output |
| sel | input | 1 | Chip select, active high |
| start_stb | input | 1 | Address strobe (polarity set by cfg_mode1) |
| acc_hold | input | 1 | Held high to keep the access open; its fall ends the access |
| wr_cyc | input | 1 | High for a write access |
| col_keep | input | LANES | Per-lane column strobe keep |
| busy | input | 1 | Array owned by refresh, second port or transfer |
| row_stb_o | output | 1 | Row strobe, active high |
| col_sel_o | output | 1 | Address mux select, 1 = column address |
| col_stb_o | output | LANES | Column strobes, active high |
| rd_oe_o | output | 1 | Read-output enable |
| ack_o | output | 1 | Access acknowledge |

## Verification
Accesses are run in both start styles, both idle and blocked: the array may be busy, or the request may arrive during precharge. This separates the immediate start from the registered start and from the pending path. Read and write accesses with the write delay on show whether the extra edge depends on the access type. Strobes during an access are sent too early, at the allowed point, and with pipelining off, and each gives a different result: one extra access or none. Lane-keep patterns held high and then released lane by lane tell the extended column strobe and its read-output enable apart from the plain end of an access.

// File: rtl/vram_acc_pkg.sv
// Shared types for the DRAM access sequencer.
// Assumes: nothing beyond the standard language.
package vram_acc_pkg;
    // Phase of the current access.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no access open; precharge may be running
        ST_ROW   = 2'd1,   // row strobe high, row address on the mux
        ST_SETUP = 2'd2,   // column address on the mux, waiting before the column strobe
        ST_COL   = 2'd3    // column strobes high, waiting for acc_hold to fall
    } acc_st_e;
endpackage

// File: rtl/vram_acc_req.sv
// Start request capture. Finds the active transition of the address strobe
// (rising in registered style, falling in immediate style) on a registered
// copy of the strobe. Decides whether the transition is accepted: always
// when no access is open, and only after the access-hold gate when
// pipelining is on.
// Assumes: sel, start_stb and acc_hold are synchronous to clk.
module vram_acc_req (
    input  logic clk,
    input  logic rst_n,
    input  logic mode1,
    input  logic pipe,
    input  logic sel,
    input  logic start_stb,
    input  logic acc_hold,
    input  logic active,
    output logic new_req
);
    logic act;
    logic act_q;
    logic seen_q;
    logic gate;

    // Strobe in active-high form for either style.
    assign act  = mode1 ? ~start_stb : start_stb;
    // Gate for a pipelined request: hold seen at an earlier edge, or (immediate style) now.
    assign gate = mode1 ? (seen_q | acc_hold) : seen_q;
    // A transition to active, qualified by the chip select and the pipelining rule.
    assign new_req = sel & act & ~act_q & (~active | (pipe & gate));

    // Registered strobe copy and the "hold sampled high in this access" flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            act_q  <= act;
            seen_q <= active & (seen_q | acc_hold);
        end
    end

    // R12
    // no_early_pipe_chk: in registered style a request during an access needs the hold seen
    no_early_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (new_req && active && !mode1) |-> $past(acc_hold));
endmodule

// File: rtl/vram_acc_pchg.sv
// Precharge timer. Loaded with PRECHARGE when the row strobe falls, then
// counts down once per clock. ready is high when the count is zero.
// Reset leaves the timer expired.
// Assumes: PRECHARGE >= 1; load is a single-cycle pulse.
module vram_acc_pchg #(
    parameter int PRECHARGE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic row_act,
    output logic ready
);
    localparam int PW = $clog2(PRECHARGE + 1);
    localparam logic [PW-1:0] PRE_L = PW'(PRECHARGE);

    logic [PW-1:0] cnt_q;

    assign ready = (cnt_q == '0);

    // Load on row strobe release; count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= PRE_L;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // R4
    // pchg_gap_chk: the row strobe only rises once the count has run out
    pchg_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_act) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/vram_acc_seq.sv
// DRAM access sequencer top. Takes an accepted start request, waits for
// precharge and busy to clear, and steps through the row phase, the column
// setup phase and the column phase. The access closes when acc_hold falls.
// Column strobe lanes may be kept open past the end.
// Assumes: ROW_HOLD, COL_SETUP, COL_HOLD, PRECHARGE >= 1. Configuration is
// only changed while no access is open. acc_hold stays high until the
// column phase has begun.
module vram_acc_seq
    import vram_acc_pkg::*;
#(
    parameter int LANES     = 2,
    parameter int ROW_HOLD  = 2,
    parameter int COL_SETUP = 2,
    parameter int COL_HOLD  = 1,
    parameter int PRECHARGE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode1,
    input  logic             cfg_pipe,
    input  logic             cfg_cas_ext,
    input  logic             cfg_wr_delay,
    input  logic             cfg_ack_en,
    input  logic             sel,
    input  logic             start_stb,
    input  logic             acc_hold,
    input  logic             wr_cyc,
    input  logic [LANES-1:0] col_keep,
    input  logic             busy,
    output logic             row_stb_o,
    output logic             col_sel_o,
    output logic [LANES-1:0] col_stb_o,
    output logic             rd_oe_o,
    output logic             ack_o
);
    localparam int T1   = (ROW_HOLD > COL_SETUP + 1) ? ROW_HOLD : COL_SETUP + 1;
    localparam int TMAX = (T1 > COL_HOLD) ? T1 : COL_HOLD;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] RH_L = TW'(ROW_HOLD - 1);
    localparam logic [TW-1:0] CS_L = TW'(COL_SETUP - 1);
    localparam logic [TW-1:0] CH_L = TW'(COL_HOLD - 1);

    acc_st_e          st_q;
    logic [TW-1:0]    tmr_q;
    logic             ras_q, col_q, ack_q, wr_q, pend_q;
    logic [LANES-1:0] cas_q;
    logic             new_req, pc_ready, active, want, go, fast, ras_fall;

    assign active   = (st_q != ST_IDLE);
    assign want     = pend_q | new_req;
    assign go       = ~active & want & pc_ready & ~busy;
    assign fast     = cfg_mode1 & new_req & ~active & pc_ready & ~busy;
    assign ras_fall = (st_q == ST_COL) & ~acc_hold;

    vram_acc_req u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode1    (cfg_mode1),
        .pipe     (cfg_pipe),
        .sel      (sel),
        .start_stb(start_stb),
        .acc_hold (acc_hold),
        .active   (active),
        .new_req  (new_req)
    );

    vram_acc_pchg #(.PRECHARGE(PRECHARGE)) u_pchg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ras_fall),
        .row_act(ras_q),
        .ready  (pc_ready)
    );

    // Pending request latch: keeps a request until it can start.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= want & ~go;
    end

    // Access phase sequencing and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            tmr_q <= '0;
            ras_q <= 1'b0;
            col_q <= 1'b0;
            ack_q <= 1'b0;
            wr_q  <= 1'b0;
            cas_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (go) begin
                        st_q  <= ST_ROW;
                        ras_q <= 1'b1;
                        tmr_q <= RH_L;
                        wr_q  <= wr_cyc;
                        cas_q <= '0;
                    end else begin
                        cas_q <= cas_q & col_keep;
                    end
                end
                ST_ROW: begin
                    if (tmr_q == '0) begin
                        st_q  <= ST_SETUP;
                        col_q <= 1'b1;
                        tmr_q <= CS_L + TW'(cfg_wr_delay & wr_q);
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (tmr_q == '0) begin
                        st_q  <= ST_COL;
                        cas_q <= '1;
                        ack_q <= cfg_ack_en;
                        tmr_q <= CH_L;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_COL: begin
                    if (!acc_hold) begin
                        st_q  <= ST_IDLE;
                        ras_q <= 1'b0;
                        col_q <= 1'b0;
                        ack_q <= 1'b0;
                        cas_q <= cfg_cas_ext ? col_keep : '0;
                    end else if (tmr_q != '0) begin
                        tmr_q <= tmr_q - 1'b1;
                    end else if (cfg_pipe) begin
                        col_q <= 1'b0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign row_stb_o = ras_q | fast;
    assign col_sel_o = col_q;
    assign col_stb_o = cas_q;
    assign ack_o     = ack_q;
    assign rd_oe_o   = cfg_cas_ext & ~wr_q & (|cas_q);

    // R8
    // ras_release_chk: the row strobe only falls after acc_hold was sampled low
    ras_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_q) |-> !$past(acc_hold));

    // R4
    // pchg_start_chk: a row strobe release always starts the precharge count
    pchg_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_q) |-> !pc_ready);

    // R5
    // cas_after_col_chk: column strobes rise only with the column address selected
    cas_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|cas_q) && ras_q) |-> col_q);

    // R7
    // col_hold_np_chk: without pipelining the column address stays through the column phase
    col_hold_np_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COL && !cfg_pipe) |-> col_q);

    // R11
    // ack_with_cas_chk: acknowledge is never high without the column strobes
    ack_with_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> (|cas_q));
endmodule

// File: tb/sim_vram_acc_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the access task pushes expected output transitions
// (signal, value, edge index) into a queue; a monitor pops and compares them
// as the outputs change.
module sim_vram_acc_seq;
    localparam int LANES = 2;
    localparam int RH    = 2;
    localparam int CSU   = 2;
    localparam int CH    = 1;
    localparam int PRE   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mode1 = 0, cfg_pipe = 0, cfg_cas_ext = 0, cfg_wr_delay = 0, cfg_ack_en = 1;
    logic sel = 0, start_stb = 0, acc_hold = 0, wr_cyc = 0, busy = 0;
    logic [LANES-1:0] col_keep = '0;
    logic row_stb_o, col_sel_o, rd_oe_o, ack_o;
    logic [LANES-1:0] col_stb_o;

    typedef struct { int sig; bit val; int cyc; string rq; } ev_t;
    ev_t evq[$];

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int last_fall = -100;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vram_acc_seq #(.LANES(LANES), .ROW_HOLD(RH), .COL_SETUP(CSU),
                   .COL_HOLD(CH), .PRECHARGE(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode1(cfg_mode1), .cfg_pipe(cfg_pipe),
        .cfg_cas_ext(cfg_cas_ext), .cfg_wr_delay(cfg_wr_delay), .cfg_ack_en(cfg_ack_en),
        .sel(sel), .start_stb(start_stb), .acc_hold(acc_hold), .wr_cyc(wr_cyc),
        .col_keep(col_keep), .busy(busy), .row_stb_o(row_stb_o), .col_sel_o(col_sel_o),
        .col_stb_o(col_stb_o), .rd_oe_o(rd_oe_o), .ack_o(ack_o)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", rq, act, exp, $time);
        end
    endtask

    function automatic void push(input int sig, input bit val, input int c, input string rq);
        ev_t e;
        e.sig = sig; e.val = val; e.cyc = c; e.rq = rq;
        evq.push_back(e);
    endfunction

    // Expected transitions of one access starting at edge e0, column phase at ec, end at ee.
    function automatic void push_access(input bit m1, input bit w, input int e0,
                                        input int ec, input int ee, input bit extkeep);
        push(0, 1, e0, m1 ? "R3" : "R2");
        push(1, 1, e0 + RH, "R5");
        push(2, 1, ec, (cfg_wr_delay && w) ? "R6" : "R5");
        if (cfg_ack_en) push(3, 1, ec, "R11");
        if (cfg_pipe) push(1, 0, ec + CH, "R7");
        push(0, 0, ee, "R8");
        if (!cfg_pipe) push(1, 0, ee, "R7");
        if (!extkeep) push(2, 0, ee, "R8");
        if (cfg_ack_en) push(3, 0, ee, "R8");
    endfunction

    // Monitor: compare each output transition against the queue head.
    initial begin
        bit prev [4];
        bit cur  [4];
        ev_t e;
        for (int i = 0; i < 4; i++) prev[i] = 1'b0;
        forever begin
            @(posedge clk);
            #3;
            cur[0] = row_stb_o; cur[1] = col_sel_o; cur[2] = |col_stb_o; cur[3] = ack_o;
            for (int i = 0; i < 4; i++) begin
                if (cur[i] !== prev[i]) begin
                    if (evq.size() == 0) begin
                        chk(1'b0, "R8 unexpected transition on signal", i, -1);
                    end else begin
                        e = evq.pop_front();
                        chk(e.sig == i && e.val == cur[i] && e.cyc == cyc,
                            e.rq, i * 1000000 + cur[i] * 100000 + cyc,
                            e.sig * 1000000 + e.val * 100000 + e.cyc);
                    end
                    prev[i] = cur[i];
                end
            end
        end
    end

    // Driver: one access with optional busy wait, hold length, and re-request.
    // rearm: 0 none, 1 early strobe (registered style), 2 strobe at the allowed point.
    task automatic access(input bit m1, input bit w, input int busy_cyc, input int hold,
                          input int rearm, input int gap);
        int s, e0, ec, ee, e0b, ec2, ee2, lastend, c, step;
        bit second, extkeep;
        @(negedge clk);
        s  = cyc + 1;
        e0 = s + busy_cyc;
        if (last_fall + PRE + 1 > e0) e0 = last_fall + PRE + 1;
        ec = e0 + RH + CSU + ((cfg_wr_delay && w) ? 1 : 0);
        ee = ec + hold;
        second  = (rearm == 2) && cfg_pipe;
        extkeep = cfg_cas_ext && (col_keep != '0);
        push_access(m1, w, e0, ec, ee, extkeep);
        lastend = ee;
        if (second) begin
            e0b = ee + PRE + 1;
            ec2 = e0b + RH + CSU + ((cfg_wr_delay && w) ? 1 : 0);
            ee2 = ec2 + 2;
            push_access(m1, w, e0b, ec2, ee2, 1'b0);
            lastend = ee2;
        end
        last_fall = lastend;
        busy = (busy_cyc > 0);
        sel = 1'b1;
        wr_cyc = w;
        start_stb = m1 ? 1'b0 : 1'b1;
        #1;
        chk(row_stb_o == (m1 && e0 == s), m1 ? "R3 immediate row strobe" : "R2 no early row strobe",
            row_stb_o, (m1 && e0 == s));
        forever begin
            @(negedge clk);
            c = cyc;
            step = c - s + 1;
            if (c >= s + busy_cyc - 1) busy = 1'b0;
            if (!m1) begin
                if (step == 1) start_stb = 1'b0;
                if (step == 2 && rearm == 1) start_stb = 1'b1;
                if (step == 3) start_stb = (rearm == 2);
                if (step == 4) start_stb = 1'b0;
            end else begin
                if (step == 2 && rearm == 2) start_stb = 1'b1;
                if (step == 3 && rearm == 2) start_stb = 1'b0;
            end
            if (step == 2) acc_hold = 1'b1;
            if (c == ee - 1) acc_hold = 1'b0;
            if (second && c == ee) acc_hold = 1'b1;
            if (second && c == ee2 - 1) acc_hold = 1'b0;
            if (c == ec) begin
                #1;
                // R10
                chk(rd_oe_o == (cfg_cas_ext && !w), "R10 read-output enable in column phase",
                    rd_oe_o, (cfg_cas_ext && !w));
            end
            if (c >= lastend + (m1 ? 3 : 0) + gap) begin
                if (m1) start_stb = 1'b1;
                sel = 1'b0;
                break;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1
        chk(row_stb_o == 0 && col_sel_o == 0 && col_stb_o == '0 && rd_oe_o == 0 && ack_o == 0,
            "R1 reset outputs", {row_stb_o, col_sel_o, col_stb_o, rd_oe_o, ack_o}, 0);

        // R1 R2 R5 R8 R11: plain registered-style read, first access needs no precharge wait
        access(0, 0, 0, 3, 0, 6);
        // R6: write with the delay enabled
        cfg_wr_delay = 1;
        access(0, 1, 0, 3, 0, 6);
        // R6: read with the delay enabled gets no extra edge
        access(0, 0, 0, 3, 0, 6);
        cfg_wr_delay = 0;
        // R4: busy wait, then a request arriving during precharge
        access(0, 0, 4, 3, 0, 0);
        access(0, 0, 0, 3, 0, 6);
        // R7 R12: pipelined column hold; early strobe dropped; allowed strobe kept
        cfg_pipe = 1;
        access(0, 0, 0, 4, 1, 6);
        access(0, 0, 0, 4, 2, 6);
        // R12: no pipelining, strobe during the access is dropped
        cfg_pipe = 0;
        access(0, 0, 0, 4, 2, 6);
        // R11: acknowledge disabled
        cfg_ack_en = 0;
        access(0, 0, 0, 3, 0, 6);
        cfg_ack_en = 1;

        // R9 R10: extended column strobes on a read, released lane by lane
        cfg_cas_ext = 1;
        col_keep = '1;
        access(0, 0, 0, 3, 0, 0);
        #1;
        chk(col_stb_o == 2'b11 && row_stb_o == 0, "R9 lanes kept after row strobe fall",
            {row_stb_o, col_stb_o}, 3);
        chk(rd_oe_o == 1, "R10 read-output enable follows kept lanes", rd_oe_o, 1);
        col_keep[0] = 1'b0;
        @(negedge clk);
        #1;
        chk(col_stb_o == 2'b10, "R9 lane 0 released", col_stb_o, 2);
        chk(rd_oe_o == 1, "R10 read-output enable with one lane", rd_oe_o, 1);
        push(2, 0, cyc + 1, "R9");
        col_keep[1] = 1'b0;
        @(negedge clk);
        #1;
        chk(col_stb_o == 2'b00 && rd_oe_o == 0, "R9 R10 all lanes released",
            {col_stb_o, rd_oe_o}, 0);
        repeat (6) @(negedge clk);
        // R10: write with extension on keeps the read-output enable low
        access(0, 1, 0, 3, 0, 6);
        cfg_cas_ext = 0;

        // Immediate style
        @(negedge clk);
        start_stb = 1'b1;
        cfg_mode1 = 1'b1;
        repeat (2) @(negedge clk);
        // R3 R13: immediate start; strobe held low past the end starts nothing
        access(1, 0, 0, 3, 0, 6);
        // R4: busy blocks the immediate start
        access(1, 0, 3, 3, 0, 6);
        // R12: pipelined re-request in immediate style
        cfg_pipe = 1;
        access(1, 0, 0, 4, 2, 6);
        cfg_pipe = 0;
        // R13: re-strobe while active without pipelining is dropped
        access(1, 0, 0, 4, 2, 6);

        repeat (8) @(negedge clk);
        chk(evq.size() == 0, "R8 all expected transitions seen", evq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule